// File: doc/BRIEF.md
# Board Control and Status Register Block

This block is a small register file placed on a simple single-cycle register bus. It gives software two fixed read-only identification words: a build date and the processor clock rate in hertz. It also drives a bank of LED outputs from a read/write register and shows the state of DIP switch inputs through a read-only register. A write of one magic data value to the reset-request register produces a one-cycle request to the board reset controller. The request is made by a two-state machine. In **IDLE** a magic write takes the transition *FIRE_ON_MAGIC* to **FIRE**, where the request output is high. **FIRE** always takes the transition *RETURN* back to **IDLE**.

The block decodes a 64 KB window. The word index, which is address bits 15:2, selects the register. Reads are registered, so read data appears in the cycle after the read enable. The switch inputs cross a two-flop synchronizer before a capture register stores them, and reads are served from that capture register.

Top module: `brd_ctl_regs`

## Requirements
- R1: A read with word index 0 (byte offset 0x00) returns 0x09272011.
- R2: A read with word index 1 (offset 0x04) returns 10,000,000 (0x00989680).
- R3: A write with word index 2 (offset 0x08) stores write-data bits LED_W-1:0 and drives them on `led_out`, where 1 means on. A read there returns that value zero-extended. The upper write-data bits are dropped.
- R4: A read with word index 3 (offset 0x0C) returns `sw_in` zero-extended, where 1 means on. A change on `sw_in` reaches this register three clock edges later. Writes to this offset have no effect.
- R5: A write of exactly 0x0000DEAD with word index 4 (offset 0x10) raises `board_rst_req` for exactly one cycle, starting in the cycle after the write. Any other data value written there raises nothing.
- R6: A read with any word index above 4 returns zero. A write with any word index other than 2 or 4 changes no output and no readable value.
- R7: After reset, `led_out`, the switch register, `board_rst_req` and `bus_rdata` are all zero.
- R8: Address bits 1:0 play no part in register selection.
- R9: Read data is valid in the cycle after `bus_rd` is high. In the cycle after a cycle without `bus_rd`, `bus_rdata` is zero.
- R10: A magic write accepted while `board_rst_req` is already high is absorbed, so the request still lasts one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (16) | Byte address inside the window |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | DATA_W (32) | Registered read data |
| sw_in | input | SW_W (8) | Asynchronous DIP switch levels |
| led_out | output | LED_W (8) | LED drive, 1 = on |
| board_rst_req | output | 1 | One-cycle board reset request |

## Verification
The assertions assume that each bus strobe is either held low or sampled as a clean level on every clock edge. They also assume that `bus_addr` and `bus_wdata` are valid whenever a strobe is high. The bench changes every input at the falling clock edge, so each value is stable at the rising edge that samples it. The switch inputs are held steady across the whole synchronizer latency before they are read back.

// File: rtl/brd_pkg.sv
package brd_pkg;

    typedef enum logic [2:0] {
        SEL_DATE = 3'd0,
        SEL_FREQ = 3'd1,
        SEL_LED  = 3'd2,
        SEL_SW   = 3'd3,
        SEL_RST  = 3'd4,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FIRE = 1'b1
    } rst_state_e;

endpackage

// File: rtl/brd_decode.sv
module brd_decode
    import brd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;

    assign idx = addr[ADDR_W-1:2];

    always_comb begin
        if (idx == IDX_W'(0))      sel = SEL_DATE;
        else if (idx == IDX_W'(1)) sel = SEL_FREQ;
        else if (idx == IDX_W'(2)) sel = SEL_LED;
        else if (idx == IDX_W'(3)) sel = SEL_SW;
        else if (idx == IDX_W'(4)) sel = SEL_RST;
        else                       sel = SEL_NONE;
    end
endmodule

// File: rtl/brd_sync.sv
module brd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/brd_rst_fsm.sv
module brd_rst_fsm
    import brd_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [31:0] MAGIC  = 32'h0000_DEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              req
);
    rst_state_e state_q, state_d;
    logic       magic;

    assign magic = wr_hit && (wdata == DATA_W'(MAGIC));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (magic) state_d = ST_FIRE;
            ST_FIRE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req = 1'b0;
        unique case (state_q)
            ST_IDLE: req = 1'b0;
            ST_FIRE: req = 1'b1;
            default: req = 1'b0;
        endcase
    end
endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
    import brd_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 32,
    parameter int          LED_W    = 8,
    parameter int          SW_W     = 8,
    parameter int          SYNC_N   = 2,
    parameter logic [31:0] ID_DATE  = 32'h0927_2011,
    parameter logic [31:0] CLK_HZ   = 32'd10_000_000,
    parameter logic [31:0] RST_KEY  = 32'h0000_DEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SW_W-1:0]   sw_in,
    output logic [LED_W-1:0]  led_out,
    output logic              board_rst_req
);
    reg_sel_e          sel;
    logic [LED_W-1:0]  led_q;
    logic [SW_W-1:0]   sw_sync;
    logic [SW_W-1:0]   sw_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    brd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    brd_sync #(.WIDTH(SW_W), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sw_in),
        .dout  (sw_sync)
    );

    brd_rst_fsm #(.DATA_W(DATA_W), .MAGIC(RST_KEY)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (bus_wr && (sel == SEL_RST)),
        .wdata  (bus_wdata),
        .req    (board_rst_req)
    );

    // LED storage
    always_ff @(posedge clk) begin
        if (!rst_n)                        led_q <= '0;
        else if (bus_wr && sel == SEL_LED) led_q <= bus_wdata[LED_W-1:0];
    end

    // switch capture after the synchronizer
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= '0;
        else        sw_q <= sw_sync;
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_DATE: rd_mux = DATA_W'(ID_DATE);
            SEL_FREQ: rd_mux = DATA_W'(CLK_HZ);
            SEL_LED:  rd_mux = DATA_W'(led_q);
            SEL_SW:   rd_mux = DATA_W'(sw_q);
            SEL_RST:  rd_mux = '0;
            SEL_NONE: rd_mux = '0;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign led_out   = led_q;
endmodule

// File: rtl/brd_ctl_regs_chk.sv
module brd_ctl_regs_chk #(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 32,
    parameter int          LED_W   = 8,
    parameter logic [31:0] ID_DATE = 32'h0927_2011,
    parameter logic [31:0] CLK_HZ  = 32'd10_000_000,
    parameter logic [31:0] RST_KEY = 32'h0000_DEAD
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LED_W-1:0]  led_out,
    input logic              board_rst_req
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    assign widx = bus_addr[ADDR_W-1:2];

    AST_DATE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && widx == IDX_W'(0)) |=> bus_rdata == DATA_W'(ID_DATE)); // R1

    AST_FREQ_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && widx == IDX_W'(1)) |=> bus_rdata == DATA_W'(CLK_HZ)); // R2

    AST_LED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == IDX_W'(2)) |=> led_out == $past(bus_wdata[LED_W-1:0])); // R3

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && widx == IDX_W'(2)) |=> $stable(led_out)); // R6

    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(board_rst_req) |-> $past(bus_wr && widx == IDX_W'(4) && bus_wdata == DATA_W'(RST_KEY))); // R5

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        board_rst_req |=> !board_rst_req); // R10

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0); // R9

    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && widx > IDX_W'(4)) |=> bus_rdata == '0); // R6
endmodule

bind brd_ctl_regs brd_ctl_regs_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LED_W  (LED_W),
    .ID_DATE(ID_DATE),
    .CLK_HZ (CLK_HZ),
    .RST_KEY(RST_KEY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .led_out      (led_out),
    .board_rst_req(board_rst_req)
);

// File: tb/tb_brd_ctl_regs.sv
module tb_brd_ctl_regs;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int LED_W  = 8;
    localparam int SW_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic [SW_W-1:0]   sw_in = '0;
    logic [LED_W-1:0]  led_out;
    logic              board_rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brd_ctl_regs dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rd       (bus_rd),
        .bus_rdata    (bus_rdata),
        .sw_in        (sw_in),
        .led_out      (led_out),
        .board_rst_req(board_rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one-cycle read; returns data sampled at the following falling edge
    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // one-cycle write; ends at the falling edge after the accepting edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic logic [31:0] expect_read(input int idx, input logic [7:0] led, input logic [7:0] sw);
        case (idx)
            0: return 32'h0927_2011;
            1: return 32'd10_000_000;
            2: return {24'd0, led};
            3: return {24'd0, sw};
            default: return 32'd0;
        endcase
    endfunction

    initial begin
        logic [31:0] d;
        sw_in = 8'hA5;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state, read before synchronized switches arrive
        check("R7 led_out", {24'd0, led_out}, 32'd0);
        check("R7 req", {31'd0, board_rst_req}, 32'd0);
        check("R7 rdata", bus_rdata, 32'd0);
        rd(16'h000C, d); check("R7 switch reg", d, 32'd0);
        rd(16'h0008, d); check("R7 led reg", d, 32'd0);
        sw_in = 8'h00;
        repeat (4) @(negedge clk);

        // R9: idle cycle returns zero
        check("R9 idle rdata", bus_rdata, 32'd0);

        // R1 R2 R6 R8: sweep word indices 0..15 with every low-bit pattern
        wr(16'h0008, 32'h0000_003C);
        for (int i = 0; i < 16; i++) begin
            for (int b = 0; b < 4; b++) begin
                rd(ADDR_W'(i*4 + b), d);
                check(i == 0 ? "R1 date" : i == 1 ? "R2 freq" : i > 4 ? "R6 undefined" : "R8 alias",
                      d, expect_read(i, 8'h3C, 8'h00));
            end
        end
        // R6: far offsets inside the window
        rd(16'h0100, d); check("R6 far", d, 32'd0);
        rd(16'hFFFC, d); check("R6 top", d, 32'd0);
        rd(16'h8008, d); check("R6 high bit", d, 32'd0);

        // R3: LED sweep with junk in upper bits
        for (int v = 0; v < 256; v++) begin
            wr(ADDR_W'(8 + (v % 4)), 32'hABCD_EF00 | 32'(v));
            check("R3 led_out", {24'd0, led_out}, 32'(v));
            rd(16'h0008, d); check("R3 led read", d, 32'(v));
        end

        // R6 R4: writes to read-only and unmapped offsets are ignored
        wr(16'h0008, 32'h0000_0055);
        wr(16'h0000, 32'hFFFF_FFFF);
        wr(16'h0004, 32'h1234_5678);
        wr(16'h000C, 32'hFFFF_FFFF);
        wr(16'h0014, 32'hFFFF_FFFF);
        wr(16'h0408, 32'h0000_00FF);
        check("R6 led after stray writes", {24'd0, led_out}, 32'h55);
        check("R6 no request", {31'd0, board_rst_req}, 32'd0);
        rd(16'h0000, d); check("R6 date kept", d, 32'h0927_2011);
        rd(16'h0004, d); check("R6 freq kept", d, 32'd10_000_000);
        rd(16'h000C, d); check("R4 switch write ignored", d, 32'd0);
        rd(16'h0008, d); check("R6 led kept", d, 32'h55);

        // R4: switch sweep, three edges of latency
        for (int v = 0; v < 256; v++) begin
            sw_in = SW_W'(v ^ 8'h5A);
            @(negedge clk);
            @(negedge clk);
            rd(16'h000C, d); check("R4 before latency", d, 32'((v == 0 ? 8'h00 : (v - 1) ^ 8'h5A)));
            rd(16'h000C, d); check("R4 switch read", d, 32'(v ^ 8'h5A));
        end

        // R5: magic write gives one-cycle request
        wr(16'h0010, 32'h0000_DEAD);
        check("R5 req high", {31'd0, board_rst_req}, 32'd1);
        @(negedge clk);
        check("R5 req one cycle", {31'd0, board_rst_req}, 32'd0);
        wr(16'h0013, 32'h0000_DEAD);
        check("R5 R8 req via alias", {31'd0, board_rst_req}, 32'd1);
        @(negedge clk);
        // R5: near-miss values give nothing
        for (int k = 0; k < 16; k++) begin
            logic [31:0] nv;
            nv = 32'h0000_DEAD ^ (32'd1 << (k * 2));
            wr(16'h0010, nv);
            check("R5 wrong key", {31'd0, board_rst_req}, 32'd0);
        end
        wr(16'h0030, 32'h0000_DEAD);
        check("R5 key at wrong offset", {31'd0, board_rst_req}, 32'd0);
        rd(16'h0010, d); check("R6 request reg reads zero", d, 32'd0);

        // R10: back-to-back magic writes
        bus_addr = 16'h0010; bus_wdata = 32'h0000_DEAD; bus_wr = 1'b1;
        @(negedge clk);
        check("R10 first pulse", {31'd0, board_rst_req}, 32'd1);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 absorbed", {31'd0, board_rst_req}, 32'd0);
        @(negedge clk);
        check("R10 stays low", {31'd0, board_rst_req}, 32'd0);

        // R7: reset in mid-run clears state
        wr(16'h0008, 32'h0000_00FF);
        sw_in = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 led cleared", {24'd0, led_out}, 32'd0);
        rd(16'h000C, d); check("R7 switch cleared", d, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule